// File: doc/BRIEF.md
# Segment Descriptor Loader with Hidden Cache

This block models one protected-mode segment register. A 16-bit selector written on the load port is split into a descriptor index, a table-select bit and a requested privilege level. The block then reads the 8-byte descriptor for that index from either the global or the local descriptor table. Both tables live in a byte-addressed, little-endian memory that is reached through a 32-bit read port with a request/ready handshake. The base, limit and access rights from the descriptor are kept in a hidden cache.

Once the cache is loaded, offsets given on the translation port turn into linear addresses without any further memory traffic. The block limit-checks each offset against the cached limit. An offset above the limit, a segment that was never loaded, and the null descriptor all raise a fault flag and yield a zero address.

The fetch engine is a three-state machine:
- `ST_IDLE`: waiting for a load.
- `ST_LO`: the low dword read is outstanding.
- `ST_HI`: the high dword read is outstanding.

It has four transitions:
- IDLE→LO: a non-null load is accepted.
- LO→HI: the low read returns.
- HI→IDLE: the high read returns and the cache is committed.
- IDLE→IDLE: a null load, which invalidates the cache without any reads.

Top module: `seg_desc_loader`

## Requirements
- R1: The selector is split as index = sel[15:3], table bit = sel[2] (0 global table, 1 local table), privilege = sel[1:0]. The privilege field does not change the fetch or the translation. After a completed load, `seg_sel` shows the whole selector.
- R2: A non-null load makes exactly two reads. The first is at table_base + 8×index and the second is at that address + 4. Each request keeps its address steady until `mem_ready`.
- R3: Descriptor bytes 0–1 are the limit, bytes 2–4 are the base, byte 5 is the rights, and bytes 6–7 are ignored. All fields are little-endian. In dword terms: limit = lo[15:0], base = {hi[7:0], lo[31:16]}, rights = hi[15:8], and `seg_rights` shows the cached rights.
- R4: `busy` is high from the cycle after a load is accepted until the cycle after the second `mem_ready`. While `busy` is high, `xl_ready` is low, and a load request has no effect.
- R5: A selector with table bit 0 and index 0 issues no reads and invalidates the cache. Every later translation faults until a successful load.
- R6: After reset `busy`, `mem_req` and `xl_done` are low, and a translation faults.
- R7: `xl_done` rises one cycle after a translation is accepted (`xl_valid` and `xl_ready`). A passing result has `xl_lin` = base + offset, with no alignment required of the base.
- R8: An offset above the cached limit faults with `xl_lin` = 0. An offset equal to the limit passes.
- R9: The cache changes only on a completed load. A change to table memory after a load does not alter later translations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request |
| ld_sel | input | 16 | Selector to load |
| gtab_base | input | 32 | Global table base address |
| ltab_base | input | 32 | Local table base address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Read byte address |
| mem_ready | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Descriptor fetch in progress |
| xl_valid | input | 1 | Translation request |
| xl_ready | output | 1 | Translation request can be taken |
| xl_off | input | 32 | Offset to translate |
| xl_done | output | 1 | Translation result valid |
| xl_lin | output | 32 | Linear address (0 on fault) |
| xl_fault | output | 1 | Protection fault |
| seg_sel | output | 16 | Cached selector |
| seg_rights | output | 8 | Cached access rights |

## Verification
The bench attacks the limit boundary with offsets equal to the limit, one above it, and a limit of 0xFFFF. A design that used `>=` would fault on the last byte, and one that compared with too few bits would wrap. It checks both read addresses of every fetch. A wrong index scale or a swapped table bit would read the wrong descriptor, and dword halves in the wrong order would scramble the base. Directed cases cover:
- the null selector, where a design that still fetched or kept the old cache would translate instead of faulting;
- the local-table index 0, which must not be treated as null;
- a load and a translation presented while busy, which a design that did not stall them would act on;
- a table rewrite after loading, which a design that re-read memory would follow.

// File: rtl/segld_pkg.sv
package segld_pkg;
    localparam int SEL_W   = 16;
    localparam int IDX_W   = 13;
    localparam int RPL_W   = 2;
    localparam int LIM_W   = 16;
    localparam int BASE_W  = 24;
    localparam int RIGHT_W = 8;
    localparam int ENT_SH  = 3;   // 8-byte descriptors
    localparam int HI_OFS  = 4;   // second dword offset

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO,
        ST_HI
    } fetch_st_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             ti;
        logic [RPL_W-1:0] rpl;
    } sel_fields_t;
endpackage

// File: rtl/segld_sel_decode.sv
module segld_sel_decode
    import segld_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [AW-1:0]    gbase,
    input  logic [AW-1:0]    lbase,
    output logic             is_null,
    output logic [AW-1:0]    entry_addr
);
    sel_fields_t f;
    logic [AW-1:0] tbase;
    logic [AW-1:0] scaled;

    always_comb begin
        f          = sel_fields_t'(sel);
        tbase      = f.ti ? lbase : gbase;
        scaled     = AW'({f.idx, {ENT_SH{1'b0}}});
        entry_addr = tbase + scaled;
        is_null    = (f.ti == 1'b0) && (f.idx == '0);
    end
endmodule

// File: rtl/segld_fetch_fsm.sv
module segld_fetch_fsm
    import segld_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_null,
    input  logic [AW-1:0] entry_addr,
    input  logic          mem_ready,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          busy,
    output logic          commit,
    output logic          commit_null,
    output logic [DW-1:0] lo_word
);
    fetch_st_t st, st_nx;
    logic [AW-1:0] addr_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start && !start_null) st_nx = ST_LO;
            ST_LO:   if (mem_ready) st_nx = ST_HI;
            ST_HI:   if (mem_ready) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            addr_q  <= '0;
            lo_word <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && start && !start_null)
                addr_q <= entry_addr;
            else if (st == ST_LO && mem_ready) begin
                addr_q  <= addr_q + AW'(HI_OFS);
                lo_word <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_req     = 1'b0;
        busy        = 1'b0;
        commit      = 1'b0;
        commit_null = 1'b0;
        mem_addr    = addr_q;
        unique case (st)
            ST_IDLE: commit_null = start && start_null;
            ST_LO: begin
                mem_req = 1'b1;
                busy    = 1'b1;
            end
            ST_HI: begin
                mem_req = 1'b1;
                busy    = 1'b1;
                commit  = mem_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/segld_cache.sv
module segld_cache
    import segld_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SEL_W-1:0]   sel_in,
    input  logic               commit,
    input  logic               commit_null,
    input  logic [DW-1:0]      lo_word,
    input  logic [DW-1:0]      hi_word,
    output logic               valid,
    output logic [BASE_W-1:0]  base,
    output logic [LIM_W-1:0]   limit,
    output logic [RIGHT_W-1:0] rights,
    output logic [SEL_W-1:0]   sel_q
);
    logic [SEL_W-1:0] pend_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            base     <= '0;
            limit    <= '0;
            rights   <= '0;
            sel_q    <= '0;
            pend_sel <= '0;
        end else begin
            if (start) pend_sel <= sel_in;
            if (commit_null) begin
                valid  <= 1'b0;
                sel_q  <= sel_in;
                base   <= '0;
                limit  <= '0;
                rights <= '0;
            end else if (commit) begin
                valid  <= 1'b1;
                sel_q  <= pend_sel;
                limit  <= lo_word[LIM_W-1:0];
                base   <= {hi_word[7:0], lo_word[31:16]};
                rights <= hi_word[15:8];
            end
        end
    end
endmodule

// File: rtl/segld_xlate.sv
module segld_xlate
    import segld_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [OW-1:0]     off,
    input  logic              valid,
    input  logic [BASE_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    output logic              done,
    output logic [AW-1:0]     lin,
    output logic              fault
);
    logic          over;
    logic          bad;
    logic [AW-1:0] sum;

    always_comb begin
        over = off > OW'(limit);
        bad  = !valid || over;
        sum  = AW'(base) + AW'(off);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            lin   <= '0;
            fault <= 1'b0;
        end else begin
            done  <= req;
            fault <= req && bad;
            lin   <= (req && !bad) ? sum : '0;
        end
    end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
    import segld_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int OW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic [SEL_W-1:0]   ld_sel,
    input  logic [AW-1:0]      gtab_base,
    input  logic [AW-1:0]      ltab_base,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_ready,
    input  logic [DW-1:0]      mem_rdata,
    output logic               busy,
    input  logic               xl_valid,
    output logic               xl_ready,
    input  logic [OW-1:0]      xl_off,
    output logic               xl_done,
    output logic [AW-1:0]      xl_lin,
    output logic               xl_fault,
    output logic [SEL_W-1:0]   seg_sel,
    output logic [RIGHT_W-1:0] seg_rights
);
    logic              accept;
    logic              is_null;
    logic [AW-1:0]     entry_addr;
    logic              commit;
    logic              commit_null;
    logic [DW-1:0]     lo_word;
    logic              c_valid;
    logic [BASE_W-1:0] c_base;
    logic [LIM_W-1:0]  c_limit;

    assign accept   = ld_valid && !busy;
    assign xl_ready = !busy;

    segld_sel_decode #(.AW(AW)) u_dec (
        .sel        (ld_sel),
        .gbase      (gtab_base),
        .lbase      (ltab_base),
        .is_null    (is_null),
        .entry_addr (entry_addr)
    );

    segld_fetch_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_null  (is_null),
        .entry_addr  (entry_addr),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .busy        (busy),
        .commit      (commit),
        .commit_null (commit_null),
        .lo_word     (lo_word)
    );

    segld_cache #(.DW(DW)) u_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .sel_in      (ld_sel),
        .commit      (commit),
        .commit_null (commit_null),
        .lo_word     (lo_word),
        .hi_word     (mem_rdata),
        .valid       (c_valid),
        .base        (c_base),
        .limit       (c_limit),
        .rights      (seg_rights),
        .sel_q       (seg_sel)
    );

    segld_xlate #(.AW(AW), .OW(OW)) u_xl (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (xl_valid && xl_ready),
        .off   (xl_off),
        .valid (c_valid),
        .base  (c_base),
        .limit (c_limit),
        .done  (xl_done),
        .lin   (xl_lin),
        .fault (xl_fault)
    );
endmodule

// File: rtl/segld_checker.sv
module segld_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready,
    input logic          busy,
    input logic          xl_valid,
    input logic          xl_ready,
    input logic          xl_done,
    input logic [AW-1:0] xl_lin,
    input logic          xl_fault
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    assert_second_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_req && mem_ready) && mem_req) |-> (mem_addr == $past(mem_addr) + AW'(4)));

    assert_req_inside_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !xl_ready);

    assert_done_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |-> $past(xl_valid && xl_ready));

    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> (xl_done && xl_lin == '0));
endmodule

bind seg_desc_loader segld_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .busy      (busy),
    .xl_valid  (xl_valid),
    .xl_ready  (xl_ready),
    .xl_done   (xl_done),
    .xl_lin    (xl_lin),
    .xl_fault  (xl_fault)
);

// File: tb/seg_desc_loader_test.sv
module seg_desc_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GBASE = 32'h0012_3458;
    localparam logic [31:0] LBASE = 32'h0040_0008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_sel = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy;
    logic        xl_valid = 1'b0;
    logic        xl_ready;
    logic [31:0] xl_off = '0;
    logic        xl_done;
    logic [31:0] xl_lin;
    logic        xl_fault;
    logic [15:0] seg_sel;
    logic [7:0]  seg_rights;

    int checks = 0;
    int fails = 0;
    int epoch = 0;
    int rd_n = 0;
    logic [31:0] rd_addr [0:7];
    int wait_cnt = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_desc_loader uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
        .gtab_base(GBASE), .ltab_base(LBASE), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .busy(busy), .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_off(xl_off),
        .xl_done(xl_done), .xl_lin(xl_lin), .xl_fault(xl_fault),
        .seg_sel(seg_sel), .seg_rights(seg_rights)
    );

    function automatic logic [63:0] desc_of(input int tbl, input int idx, input int ep);
        logic [15:0] lim;
        logic [23:0] bs;
        logic [7:0]  rt;
        lim = 16'(idx * 97 + tbl * 5 + ep * 13 + 3);
        if (idx % 5 == 4) lim = 16'hFFFF;
        bs  = 24'(idx * 7919 + tbl * 131071 + ep * 3 + 1);
        rt  = 8'(idx * 3 + tbl * 64 + ep + 7);
        return {16'hA5C3, rt, bs, lim};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [63:0] d;
        logic [31:0] o;
        if (a >= GBASE && a < GBASE + 32'h10000) begin
            o = a - GBASE;
            d = desc_of(0, int'(o >> 3), epoch);
        end else if (a >= LBASE && a < LBASE + 32'h10000) begin
            o = a - LBASE;
            d = desc_of(1, int'(o >> 3), epoch);
        end else begin
            return 32'hDEAD_BEEF;
        end
        return o[2] ? d[63:32] : d[31:0];
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            if (mem_req && rst_n) begin
                if (wait_cnt == 0) begin
                    mem_ready = 1'b1;
                    mem_rdata = mem_word(mem_addr);
                    if (rd_n < 8) rd_addr[rd_n] = mem_addr;
                    rd_n++;
                    wait_cnt = int'($urandom % 3);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 60 && busy; i++) @(negedge clk);
    endtask

    // load and check fetch addresses (R1, R2, R3, R4, R5)
    task automatic do_load(input logic [15:0] s);
        logic [31:0] ea;
        logic [63:0] d;
        logic        nul;
        nul = (s[2] == 1'b0) && (s[15:3] == 13'd0);
        ea  = (s[2] ? LBASE : GBASE) + {16'd0, s[15:3], 3'b000};
        rd_n = 0;
        ld_sel = s; ld_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        if (nul) begin
            check(!busy, "R5 null load not busy", {31'd0, busy}, 32'd0);
        end else begin
            check(busy, "R4 busy after accept", {31'd0, busy}, 32'd1);
        end
        wait_idle();
        @(negedge clk);
        if (nul) begin
            check(rd_n == 0, "R5 null reads", rd_n, 0);
        end else begin
            d = desc_of(int'(s[2]), int'(s[15:3]), epoch);
            check(rd_n == 2, "R2 read count", rd_n, 2);
            check(rd_addr[0] == ea, "R2 first addr", rd_addr[0], ea);
            check(rd_addr[1] == ea + 4, "R2 second addr", rd_addr[1], ea + 4);
            check(seg_rights == d[47:40], "R3 rights", {24'd0, seg_rights}, {24'd0, d[47:40]});
        end
        check(seg_sel == s, "R1 selector cached", {16'd0, seg_sel}, {16'd0, s});
    endtask

    task automatic do_xl(input logic [31:0] off, input logic exp_f, input logic [31:0] exp_lin, input string tag);
        xl_off = off; xl_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xl_valid = 1'b0;
        check(xl_done, {tag, " done"}, {31'd0, xl_done}, 32'd1);
        check(xl_fault == exp_f, {tag, " fault"}, {31'd0, xl_fault}, {31'd0, exp_f});
        check(xl_lin == exp_lin, {tag, " lin"}, xl_lin, exp_lin);
    endtask

    task automatic xl_against(input logic [15:0] s, input int ep);
        logic [63:0] d;
        logic [31:0] lim, bs, r;
        d   = desc_of(int'(s[2]), int'(s[15:3]), ep);
        lim = {16'd0, d[15:0]};
        bs  = {8'd0, d[39:16]};
        r   = $urandom % (lim + 1);
        do_xl(lim, 1'b0, bs + lim, "R8 offset at limit");
        do_xl(lim + 1, 1'b1, 32'd0, "R8 offset above limit");
        do_xl(r, 1'b0, bs + r, "R7 random offset");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R6 reset state
        check(!busy && !mem_req && !xl_done, "R6 reset outputs", {29'd0, busy, mem_req, xl_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        do_xl(32'd0, 1'b1, 32'd0, "R6 translate before load");

        // directed: local index 0 is not null, RPL ignored
        do_load(16'h0004);
        xl_against(16'h0004, epoch);
        do_load(16'h0007);
        xl_against(16'h0007, epoch);

        // limit 0xFFFF case (idx 4)
        do_load(16'h0020);
        xl_against(16'h0020, epoch);

        // R9 memory rewrite after load
        do_load(16'h0048);
        epoch = 5;
        xl_against(16'h0048, 0);
        epoch = 0;

        // R5 null selector (with nonzero RPL)
        do_load(16'h0003);
        do_xl(32'd0, 1'b1, 32'd0, "R5 null translation");

        // R4 load and translation while busy
        begin
            logic [63:0] d;
            rd_n = 0;
            ld_sel = 16'h0058; ld_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            ld_sel = 16'h0100;
            xl_off = 32'd1; xl_valid = 1'b1;
            check(!xl_ready, "R4 xl_ready low while busy", {31'd0, xl_ready}, 32'd0);
            @(posedge clk);
            @(negedge clk);
            ld_valid = 1'b0; xl_valid = 1'b0;
            check(!xl_done, "R4 translation stalled", {31'd0, xl_done}, 32'd0);
            wait_idle();
            @(negedge clk);
            d = desc_of(0, 11, epoch);
            check(rd_n == 2, "R4 second load ignored reads", rd_n, 2);
            check(seg_sel == 16'h0058, "R4 second load ignored sel", {16'd0, seg_sel}, 32'h58);
            check(seg_rights == d[47:40], "R4 rights from first", {24'd0, seg_rights}, {24'd0, d[47:40]});
            xl_against(16'h0058, epoch);
        end

        // random loads
        for (int k = 0; k < 40; k++) begin
            logic [15:0] s;
            s = 16'($urandom);
            if (s[2] == 1'b0 && s[15:3] == 13'd0) s[3] = 1'b1;
            do_load(s);
            xl_against(s, epoch);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule